// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block runs an eight-pin general-purpose I/O port from a small synchronous register bus. A 16-bit configuration register holds two bits per pin. Bit 2n chooses the direction of pin n. Bit 2n+1 turns the pin's pull-up off. An 8-bit output latch supplies the level that each output pin drives. The block produces three pad controls for every pin: output enable, output data and pull-up enable. It also samples the raw pin levels.

A read of the data offset returns the pin levels as they were sampled, never the latch. This lets software see the real state of a pin even when the pin is driven. The sample passes through a two-stage synchronizer. While the bus release request is high, the sample stays frozen and a status output marks any data read as possibly stale.

The output latch keeps its value through reset. Reset puts the configuration register into a safe state: every pin is an input and every pull-up is off.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A synchronous reset sets the configuration register to 16'hAAAA: all direction bits 0 (input) and all pull-up-off bits 1. In this state pad_oe and pad_pu_en read 0.
- R2: pad_oe[n] follows configuration bit 2n (1 = output) for every pin n.
- R3: pad_pu_en[n] is 1 exactly when configuration bit 2n+1 is 0, whatever the value of bit 2n.
- R4: A write to offset 2 loads bus_wdata[7:0] into the output latch. pad_out[n] equals latch bit n.
- R5: A read at offset 2 returns {8'h00, pin levels}. A pin change made before clock edge k is visible after edge k+1 and not after edge k alone. This holds for output pins too, so the latch value is never returned.
- R6: Reset leaves the output latch and pad_out unchanged.
- R7: While brq is 1, the read sample keeps the value it had before brq rose. A data read during brq raises rd_stale. rd_stale is 0 whenever brq is 0.
- R8: Offsets 1 and 3 read as zero, and writes to them change neither register.
- R9: A write to offset 0 loads all 16 bits of bus_wdata into the configuration register, and a read at offset 0 returns them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| pin_in | input | 8 | Raw pin levels |
| brq | input | 1 | Bus release request |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output level |
| pad_pu_en | output | 8 | Per-pin pull-up enable |
| rd_stale | output | 1 | Data read during bus release request |

## Verification
A vector table drives several patterns into the configuration register, the latch and the pins. These include alternating directions with mixed pull-up bits, all outputs with the pull-ups still on, and a latch value that differs from the pin levels on driven pins. Together they separate direction from pull-up decoding and a pin readback from a latch readback. Directed tests add three more checks. A single-step pin change tells a two-stage lag apart from shorter or longer ones. A pin change during the release request shows that the sample freezes. Resets and unmapped writes show that the latch and the configuration are kept.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int unsigned NPIN = 8;
    localparam int unsigned CW   = 2 * NPIN;
    localparam int unsigned AW   = 2;

    localparam logic [AW-1:0] OFS_CFG  = 2'd0;
    localparam logic [AW-1:0] OFS_DATA = 2'd2;

    // one pin's slice of the configuration word: drive sits at 2n, pu_off at 2n+1
    typedef struct packed {
        logic pu_off;
        logic drive;
    } pin_cfg_t;

    typedef pin_cfg_t [NPIN-1:0] port_cfg_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_CFG,
        ACC_DATA,
        ACC_VOID
    } acc_t;

    function automatic port_cfg_t cfg_reset();
        port_cfg_t c;
        for (int i = 0; i < NPIN; i++) begin
            c[i].drive  = 1'b0;
            c[i].pu_off = 1'b1;
        end
        return c;
    endfunction

    function automatic acc_t decode(input logic sel, input logic [AW-1:0] a);
        if (!sel)               return ACC_NONE;
        else if (a == OFS_CFG)  return ACC_CFG;
        else if (a == OFS_DATA) return ACC_DATA;
        else                    return ACC_VOID;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync
    import gpio_port_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    input  logic [NPIN-1:0] pin_raw,
    output logic [NPIN-1:0] sample
);
    logic [NPIN-1:0] meta_q;
    logic [NPIN-1:0] samp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            samp_q <= '0;
        end else begin
            meta_q <= pin_raw;
            if (!hold)
                samp_q <= meta_q;
        end
    end

    assign sample = samp_q;

    // R7
    freeze_on_hold_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(samp_q));

    // R5
    second_stage_chk: assert property (@(posedge clk) disable iff (rst)
        !hold |=> samp_q == $past(meta_q));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter logic [NPIN-1:0] DATA_INIT = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sel,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [CW-1:0]   wdata,
    output port_cfg_t       cfg,
    output logic [NPIN-1:0] latch,
    output acc_t            acc
);
    port_cfg_t       cfg_q;
    logic [NPIN-1:0] dat_q = DATA_INIT;
    logic            wr_cfg;
    logic            wr_dat;

    always_comb begin
        acc    = decode(sel, addr);
        wr_cfg = wr && (acc == ACC_CFG);
        wr_dat = wr && (acc == ACC_DATA);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= cfg_reset();
        else if (wr_cfg)
            cfg_q <= port_cfg_t'(wdata);
    end

    // latch has no reset branch: it survives every reset
    always_ff @(posedge clk) begin
        if (wr_dat)
            dat_q <= wdata[NPIN-1:0];
    end

    assign cfg   = cfg_q;
    assign latch = dat_q;

    // R1
    cfg_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> cfg_q == cfg_reset());

    // R8
    void_write_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && wr && addr != OFS_CFG && addr != OFS_DATA) |=> $stable(cfg_q) && $stable(dat_q));

    // R4
    latch_load_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && wr && addr == OFS_DATA) |=> dat_q == $past(wdata[NPIN-1:0]));

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_port_pkg::*;
(
    input  port_cfg_t       cfg,
    input  logic [NPIN-1:0] latch,
    output logic [NPIN-1:0] oe,
    output logic [NPIN-1:0] dout,
    output logic [NPIN-1:0] pu_en
);
    for (genvar n = 0; n < NPIN; n++) begin : g_pin
        assign oe[n]    = cfg[n].drive;
        assign pu_en[n] = ~cfg[n].pu_off;
        assign dout[n]  = latch[n];
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter logic [NPIN-1:0] DATA_INIT = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [CW-1:0]   bus_wdata,
    output logic [CW-1:0]   bus_rdata,
    input  logic [NPIN-1:0] pin_in,
    input  logic            brq,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_pu_en,
    output logic            rd_stale
);
    port_cfg_t       cfg;
    logic [NPIN-1:0] latch;
    logic [NPIN-1:0] sample;
    acc_t            acc;

    gpio_port_regs #(.DATA_INIT(DATA_INIT)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .sel   (bus_sel),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .cfg   (cfg),
        .latch (latch),
        .acc   (acc)
    );

    gpio_pin_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .hold    (brq),
        .pin_raw (pin_in),
        .sample  (sample)
    );

    gpio_pad_ctrl u_pad (
        .cfg   (cfg),
        .latch (latch),
        .oe    (pad_oe),
        .dout  (pad_out),
        .pu_en (pad_pu_en)
    );

    always_comb begin
        bus_rdata = '0;
        if (!bus_wr) begin
            case (acc)
                ACC_CFG:  bus_rdata = CW'(cfg);
                ACC_DATA: bus_rdata = CW'(sample);
                default:  bus_rdata = '0;
            endcase
        end
        rd_stale = brq && !bus_wr && (acc == ACC_DATA);
    end

    // R7
    stale_needs_brq_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stale |-> brq);

    // R6
    latch_through_reset_chk: assert property (@(posedge clk)
        (rst && !(bus_sel && bus_wr && bus_addr == OFS_DATA)) |=> $stable(pad_out));

endmodule

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  pin_in = '0;
    logic        brq = 1'b0;
    logic [7:0]  pad_oe, pad_out, pad_pu_en;
    logic        rd_stale;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_port_ctrl u_gpio_port_ctrl (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .brq(brq), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pu_en(pad_pu_en), .rd_stale(rd_stale)
    );

    // vector: {cfg[15:0], latch[7:0], pins[7:0]}
    localparam int NVEC = 6;
    localparam logic [31:0] VEC [NVEC] = '{
        {16'h5555, 8'hA5, 8'h3C},
        {16'h6699, 8'h0F, 8'hF0},
        {16'h0000, 8'hFF, 8'h00},
        {16'hFFFF, 8'h00, 8'hFF},
        {16'h1248, 8'h81, 8'h7E},
        {16'hAAAA, 8'h5A, 8'hA5}
    };

    function automatic logic [7:0] exp_oe(input logic [15:0] c);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = c[2*i];
        return r;
    endfunction

    function automatic logic [7:0] exp_pu(input logic [15:0] c);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = ~c[2*i+1];
        return r;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // leaves a read set up; caller samples between edges
    task automatic rd_setup(input logic [1:0] a);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2;
    endtask

    task automatic rd_end();
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd_setup(2'd0);
        check("R1 cfg", bus_rdata, 16'hAAAA);
        check("R1 oe", {8'h0, pad_oe}, 16'h0);
        check("R1 pu", {8'h0, pad_pu_en}, 16'h0);
        rd_end();

        // table walk: R2 R3 R4 R5 R9
        for (int v = 0; v < NVEC; v++) begin
            wr_reg(2'd0, VEC[v][31:16]);
            wr_reg(2'd2, {8'hEE, VEC[v][15:8]});
            pin_in = VEC[v][7:0];
            repeat (3) @(negedge clk);
            check("R2 oe", {8'h0, pad_oe}, {8'h0, exp_oe(VEC[v][31:16])});
            check("R3 pu", {8'h0, pad_pu_en}, {8'h0, exp_pu(VEC[v][31:16])});
            check("R4 out", {8'h0, pad_out}, {8'h0, VEC[v][15:8]});
            rd_setup(2'd0);
            check("R9 cfg read", bus_rdata, VEC[v][31:16]);
            bus_addr = 2'd2; #2;
            check("R5 pin read", bus_rdata, {8'h0, VEC[v][7:0]});
            rd_end();
        end

        // R5 two-cycle lag
        pin_in = 8'h11;
        repeat (3) @(negedge clk);
        pin_in = 8'h96;
        @(negedge clk);
        rd_setup(2'd2);
        check("R5 lag one edge", bus_rdata, 16'h0011);
        @(negedge clk);
        #2;
        check("R5 lag two edges", bus_rdata, 16'h0096);
        check("R7 no stale without brq", {15'h0, rd_stale}, 16'h0);
        rd_end();

        // R7 freeze during release request
        pin_in = 8'h33;
        repeat (3) @(negedge clk);
        brq = 1'b1;
        pin_in = 8'hC4;
        repeat (4) @(negedge clk);
        rd_setup(2'd2);
        check("R7 frozen sample", bus_rdata, 16'h0033);
        check("R7 stale flag", {15'h0, rd_stale}, 16'h1);
        rd_end();
        @(negedge clk);
        brq = 1'b0;
        @(negedge clk);
        rd_setup(2'd2);
        check("R7 resume", bus_rdata, 16'h00C4);
        check("R7 flag clear", {15'h0, rd_stale}, 16'h0);
        rd_end();

        // R8 unmapped offsets
        wr_reg(2'd0, 16'h1E1E);
        wr_reg(2'd2, 16'h0077);
        wr_reg(2'd1, 16'hFFFF);
        wr_reg(2'd3, 16'h0000);
        @(negedge clk);
        rd_setup(2'd1);
        check("R8 read off1", bus_rdata, 16'h0);
        bus_addr = 2'd3; #2;
        check("R8 read off3", bus_rdata, 16'h0);
        bus_addr = 2'd0; #2;
        check("R8 cfg kept", bus_rdata, 16'h1E1E);
        rd_end();
        check("R8 latch kept", {8'h0, pad_out}, 16'h0077);

        // R6 latch survives reset, R1 cfg restored
        wr_reg(2'd2, 16'h003C);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R6 latch after reset", {8'h0, pad_out}, 16'h003C);
        rd_setup(2'd0);
        check("R1 cfg after second reset", bus_rdata, 16'hAAAA);
        rd_end();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule